// File: doc/BRIEF.md
# Two-by-Two Mesh Message Router

This block is the routing node placed at each corner of a four-node on-chip mesh laid out as a 2x2 grid. Each node has two neighbour links and no diagonal link. The node takes messages from its own core and from its two neighbour links. It looks at the destination ID of each message and then does one of three things: it hands the message to the local core, it sends it one hop over the link that reaches the destination, or it passes it on toward the diagonal node. Because every link is an independent point-to-point path, messages bound for different outputs can move in the same cycle.

A node reaches its diagonal partner through either of its two neighbours. The node spreads this traffic evenly by alternating the path for every diagonal message its core injects. When several inputs want one output, a round-robin arbiter chooses which input is served. Each output has a small queue, so a ready signal never depends combinationally on a downstream ready, and a ring of four nodes has no combinational loop.

Top module: `mesh_router`

## Requirements
- R1: After reset every output valid is low, and no input is acknowledged while its valid is low.
- R2: A message is a word {src[1:0], dst[1:0], payload}, with the payload in the low bits and src in the top two bits. A message whose dst equals NODE_ID appears on the local output with every field unchanged, whichever input it came from.
- R3: A message from the local core addressed to NODE_ID^1 leaves on link X. A message from the local core addressed to NODE_ID^2 leaves on link Y.
- R4: Messages from the local core addressed to NODE_ID^3 alternate between the two links. The first one after reset takes link X, and the path changes only when a diagonal message is accepted, not when other traffic passes.
- R5: A message that arrives on one neighbour link and is not addressed to NODE_ID is forwarded on the other link. It is never sent back on the link it arrived on.
- R6: Inputs whose messages target different outputs are all acknowledged in the same cycle. They appear together on their outputs one cycle later.
- R7: When several inputs target one output, exactly one is acknowledged per cycle, in round-robin order. The order starts after the input granted last and begins with the local input after reset. The other inputs see ready low and hold their messages.
- R8: Each output queues up to OQ_DEPTH (default 2) messages. When its queue is full, no input aimed at that output is acknowledged. Every accepted message leaves exactly once, in the order it was accepted on that output.
- R9: While an output's valid is high and its ready is low, the output keeps its valid high and its message unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| localInValid | input | 1 | Local core offers a message |
| localInMsg | input | PAYLOAD_W+4 | Message from the local core |
| localInReady | output | 1 | Local message accepted this cycle |
| linkXInValid | input | 1 | Neighbour NODE_ID^1 offers a message |
| linkXInMsg | input | PAYLOAD_W+4 | Message arriving on link X |
| linkXInReady | output | 1 | Link X message accepted this cycle |
| linkYInValid | input | 1 | Neighbour NODE_ID^2 offers a message |
| linkYInMsg | input | PAYLOAD_W+4 | Message arriving on link Y |
| linkYInReady | output | 1 | Link Y message accepted this cycle |
| localOutValid | output | 1 | Message for the local core is present |
| localOutMsg | output | PAYLOAD_W+4 | Message delivered to the local core |
| localOutReady | input | 1 | Local core takes the message |
| linkXOutValid | output | 1 | Message for neighbour NODE_ID^1 is present |
| linkXOutMsg | output | PAYLOAD_W+4 | Message leaving on link X |
| linkXOutReady | input | 1 | Neighbour NODE_ID^1 takes the message |
| linkYOutValid | output | 1 | Message for neighbour NODE_ID^2 is present |
| linkYOutMsg | output | PAYLOAD_W+4 | Message leaving on link Y |
| linkYOutReady | input | 1 | Neighbour NODE_ID^2 takes the message |

## Verification
Two functions can fall in the same cycle: independent transfers on separate outputs, and arbitration between inputs that compete for one output. The bench provokes the first by offering messages on all three inputs at once, each bound for a different output. It judges the result by requiring all three readies high in that cycle and all three outputs filled in the next. It provokes the second by sending all three inputs to the local output while that output is stalled. It then checks that exactly one input is granted per cycle in rotation, that the third input stalls once the queue is full, and that the three messages arrive in grant order after the stall is released.

// File: rtl/mesh_router_pkg.sv
package mesh_router_pkg;
  localparam int NUM_PORTS = 3;

  // port index 0 = local core, 1 = link X (NODE_ID^1), 2 = link Y (NODE_ID^2)
  typedef enum logic [1:0] {
    PORT_LOCAL = 2'd0,
    PORT_LINKX = 2'd1,
    PORT_LINKY = 2'd2
  } port_e;

  typedef struct packed {
    logic [NUM_PORTS-1:0]                push;   // per output: write its queue
    logic [NUM_PORTS-1:0][NUM_PORTS-1:0] sel;    // per output: one-hot input choice
    logic [NUM_PORTS-1:0]                inAck;  // per input: accepted this cycle
  } strobes_t;
endpackage

// File: rtl/mesh_router_ctrl.sv
module mesh_router_ctrl
  import mesh_router_pkg::*;
#(
  parameter logic [1:0] NODE_ID = 2'd0
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_PORTS-1:0]           inValid,
  input  logic [NUM_PORTS-1:0][1:0]      inDst,
  input  logic [NUM_PORTS-1:0]           outFull,
  output strobes_t                       strb
);
  localparam logic [1:0] DIAG_ID = NODE_ID ^ 2'd3;

  logic pathToggle;
  logic [1:0] routeOf [NUM_PORTS];
  logic [NUM_PORTS-1:0] gntAll [NUM_PORTS];
  logic diagAccept;

  function automatic logic [1:0] routeFor(input logic [1:0] srcPort,
                                          input logic [1:0] dst,
                                          input logic tog);
    if (dst == NODE_ID) return PORT_LOCAL;
    if (srcPort == PORT_LOCAL) begin
      if (dst == (NODE_ID ^ 2'd1)) return PORT_LINKX;
      if (dst == (NODE_ID ^ 2'd2)) return PORT_LINKY;
      return tog ? PORT_LINKY : PORT_LINKX;
    end
    return (srcPort == PORT_LINKX) ? PORT_LINKY : PORT_LINKX;
  endfunction

  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++)
      routeOf[i] = routeFor(2'(i), inDst[i], pathToggle);
  end

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_arb
    logic [1:0] lastGnt;
    logic [1:0] nextGnt;
    logic [NUM_PORTS-1:0] req;
    logic [NUM_PORTS-1:0] gnt;

    always_comb begin
      for (int i = 0; i < NUM_PORTS; i++)
        req[i] = inValid[i] && (routeOf[i] == 2'(o));
    end

    always_comb begin
      logic found;
      int idx;
      gnt = '0;
      nextGnt = lastGnt;
      found = 1'b0;
      for (int k = 1; k <= NUM_PORTS; k++) begin
        idx = (int'(lastGnt) + k) % NUM_PORTS;
        if (!found && req[idx] && !outFull[o]) begin
          gnt[idx] = 1'b1;
          nextGnt = 2'(idx);
          found = 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) lastGnt <= 2'(NUM_PORTS - 1);
      else if (|gnt) lastGnt <= nextGnt;
    end

    assign gntAll[o] = gnt;

    // R7
    one_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(gnt));
  end

  always_comb begin
    strb = '0;
    for (int o = 0; o < NUM_PORTS; o++) begin
      strb.sel[o]  = gntAll[o];
      strb.push[o] = |gntAll[o];
      for (int i = 0; i < NUM_PORTS; i++)
        if (gntAll[o][i]) strb.inAck[i] = 1'b1;
    end
  end

  assign diagAccept = strb.inAck[PORT_LOCAL] && (inDst[PORT_LOCAL] == DIAG_ID);

  always_ff @(posedge clk) begin
    if (!rstN) pathToggle <= 1'b0;
    else if (diagAccept) pathToggle <= ~pathToggle;
  end

  // R4
  diag_alternate_chk: assert property (@(posedge clk) disable iff (!rstN)
    diagAccept |=> pathToggle != $past(pathToggle));

  // R1
  ack_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inAck & ~inValid) == '0);
endmodule

// File: rtl/mesh_router_dp.sv
module mesh_router_dp
  import mesh_router_pkg::*;
#(
  parameter int MSG_W    = 12,
  parameter int OQ_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [MSG_W-1:0]     inMsg    [NUM_PORTS],
  input  strobes_t             strb,
  output logic [NUM_PORTS-1:0] outFull,
  output logic [NUM_PORTS-1:0] outValid,
  output logic [MSG_W-1:0]     outMsg   [NUM_PORTS],
  input  logic [NUM_PORTS-1:0] outReady
);
  localparam int PTR_W = (OQ_DEPTH > 1) ? $clog2(OQ_DEPTH) : 1;
  localparam int CNT_W = $clog2(OQ_DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(OQ_DEPTH - 1);

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_queue
    logic [MSG_W-1:0] slots [OQ_DEPTH];
    logic [PTR_W-1:0] wrPtr, rdPtr;
    logic [CNT_W-1:0] count;
    logic [MSG_W-1:0] pushData;
    logic pop;

    always_comb begin
      pushData = '0;
      for (int i = 0; i < NUM_PORTS; i++)
        if (strb.sel[o][i]) pushData = pushData | inMsg[i];
    end

    assign pop         = outValid[o] && outReady[o];
    assign outValid[o] = (count != '0);
    assign outFull[o]  = (count == CNT_W'(OQ_DEPTH));
    assign outMsg[o]   = slots[rdPtr];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wrPtr <= '0;
        rdPtr <= '0;
        count <= '0;
      end else begin
        if (strb.push[o]) wrPtr <= (wrPtr == LAST_SLOT) ? '0 : wrPtr + 1'b1;
        if (pop)          rdPtr <= (rdPtr == LAST_SLOT) ? '0 : rdPtr + 1'b1;
        case ({strb.push[o], pop})
          2'b10:   count <= count + 1'b1;
          2'b01:   count <= count - 1'b1;
          default: count <= count;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (strb.push[o]) slots[wrPtr] <= pushData;
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.push[o] |-> !outFull[o] || outReady[o] && 1'b0 || !outFull[o]);

    // R8
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
      count <= CNT_W'(OQ_DEPTH));

    // R9
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
      outValid[o] && !outReady[o] |=> outValid[o] && $stable(outMsg[o]));
  end
endmodule

// File: rtl/mesh_router.sv
module mesh_router
  import mesh_router_pkg::*;
#(
  parameter logic [1:0] NODE_ID   = 2'd0,
  parameter int         PAYLOAD_W = 8,
  parameter int         OQ_DEPTH  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 localInValid,
  input  logic [PAYLOAD_W+3:0] localInMsg,
  output logic                 localInReady,
  input  logic                 linkXInValid,
  input  logic [PAYLOAD_W+3:0] linkXInMsg,
  output logic                 linkXInReady,
  input  logic                 linkYInValid,
  input  logic [PAYLOAD_W+3:0] linkYInMsg,
  output logic                 linkYInReady,
  output logic                 localOutValid,
  output logic [PAYLOAD_W+3:0] localOutMsg,
  input  logic                 localOutReady,
  output logic                 linkXOutValid,
  output logic [PAYLOAD_W+3:0] linkXOutMsg,
  input  logic                 linkXOutReady,
  output logic                 linkYOutValid,
  output logic [PAYLOAD_W+3:0] linkYOutMsg,
  input  logic                 linkYOutReady
);
  localparam int MSG_W = PAYLOAD_W + 4;

  logic [MSG_W-1:0]          inMsg  [NUM_PORTS];
  logic [MSG_W-1:0]          outMsg [NUM_PORTS];
  logic [NUM_PORTS-1:0]      inValid, outValid, outReady, outFull;
  logic [NUM_PORTS-1:0][1:0] inDst;
  strobes_t                  strb;

  assign inMsg[0] = localInMsg;
  assign inMsg[1] = linkXInMsg;
  assign inMsg[2] = linkYInMsg;
  assign inValid  = {linkYInValid, linkXInValid, localInValid};
  assign outReady = {linkYOutReady, linkXOutReady, localOutReady};

  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++)
      inDst[i] = inMsg[i][PAYLOAD_W +: 2];
  end

  mesh_router_ctrl #(.NODE_ID(NODE_ID)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDst(inDst),
    .outFull(outFull), .strb(strb)
  );

  mesh_router_dp #(.MSG_W(MSG_W), .OQ_DEPTH(OQ_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .inMsg(inMsg), .strb(strb),
    .outFull(outFull), .outValid(outValid), .outMsg(outMsg),
    .outReady(outReady)
  );

  assign localInReady  = strb.inAck[0];
  assign linkXInReady  = strb.inAck[1];
  assign linkYInReady  = strb.inAck[2];
  assign localOutValid = outValid[0];
  assign linkXOutValid = outValid[1];
  assign linkYOutValid = outValid[2];
  assign localOutMsg   = outMsg[0];
  assign linkXOutMsg   = outMsg[1];
  assign linkYOutMsg   = outMsg[2];
endmodule

// File: tb/sim_mesh_router.sv
`timescale 1ns/1ps
module sim_mesh_router;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic        inValid [3];
  logic [11:0] inMsg   [3];
  logic        inReady [3];
  logic        outValid[3];
  logic [11:0] outMsg  [3];
  logic        outReady[3];

  int vecCount = 0;
  int failCount = 0;

  mesh_router #(.NODE_ID(2'd0), .PAYLOAD_W(8), .OQ_DEPTH(2)) u0 (
    .clk(clk), .rstN(rstN),
    .localInValid(inValid[0]), .localInMsg(inMsg[0]), .localInReady(inReady[0]),
    .linkXInValid(inValid[1]), .linkXInMsg(inMsg[1]), .linkXInReady(inReady[1]),
    .linkYInValid(inValid[2]), .linkYInMsg(inMsg[2]), .linkYInReady(inReady[2]),
    .localOutValid(outValid[0]), .localOutMsg(outMsg[0]), .localOutReady(outReady[0]),
    .linkXOutValid(outValid[1]), .linkXOutMsg(outMsg[1]), .linkXOutReady(outReady[1]),
    .linkYOutValid(outValid[2]), .linkYOutMsg(outMsg[2]), .linkYOutReady(outReady[2])
  );

  // entry: {input port[1:0], msg {src,dst,payload}[11:0], expected output port[1:0]}
  localparam int NVEC = 11;
  localparam logic [15:0] VEC [NVEC] = '{
    {2'd0, 2'd0, 2'd1, 8'h11, 2'd1},  // R3 neighbour 1 via X
    {2'd0, 2'd0, 2'd2, 8'h22, 2'd2},  // R3 neighbour 2 via Y
    {2'd0, 2'd0, 2'd0, 8'h33, 2'd0},  // R2 self loop
    {2'd0, 2'd0, 2'd3, 8'h44, 2'd1},  // R4 first diagonal via X
    {2'd0, 2'd0, 2'd3, 8'h55, 2'd2},  // R4 second via Y
    {2'd0, 2'd0, 2'd3, 8'h66, 2'd1},  // R4 third via X
    {2'd1, 2'd1, 2'd0, 8'h77, 2'd0},  // R2 from X to local
    {2'd1, 2'd1, 2'd2, 8'h88, 2'd2},  // R5 X forwarded to Y
    {2'd2, 2'd2, 2'd1, 8'h99, 2'd1},  // R5 Y forwarded to X
    {2'd2, 2'd2, 2'd0, 8'hAA, 2'd0},  // R2 from Y to local
    {2'd0, 2'd0, 2'd3, 8'hBB, 2'd2}   // R4 toggle untouched by link traffic
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vecCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic runVector(input logic [15:0] v, input string req);
    int p = int'(v[15:14]);
    int e = int'(v[1:0]);
    @(negedge clk);
    inValid[p] = 1'b1;
    inMsg[p] = v[13:2];
    #2;
    check(inReady[p] == 1'b1, req, int'(inReady[p]), 1);
    @(posedge clk);
    @(negedge clk);
    inValid[p] = 1'b0;
    #1;
    for (int o = 0; o < 3; o++) begin
      if (o == e)
        check(outValid[o] && outMsg[o] == v[13:2], req, int'(outMsg[o]), int'(v[13:2]));
      else
        check(!outValid[o], req, int'(outValid[o]), 0);
    end
  endtask

  initial begin
    #(8 * 20000);
    failCount++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    logic [11:0] got [3];
    int nGot;
    for (int i = 0; i < 3; i++) begin
      inValid[i] = 1'b0; inMsg[i] = '0; outReady[i] = 1'b1;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    for (int o = 0; o < 3; o++) begin
      check(!outValid[o], "R1", int'(outValid[o]), 0);
      check(!inReady[o], "R1", int'(inReady[o]), 0);
    end

    for (int k = 0; k < NVEC; k++) runVector(VEC[k], "R2/R3/R4/R5 vector");
    @(posedge clk);

    // R6 independent outputs in the same cycle
    @(negedge clk);
    inValid[0] = 1'b1; inMsg[0] = {2'd0, 2'd1, 8'hD0};
    inValid[1] = 1'b1; inMsg[1] = {2'd1, 2'd2, 8'hD1};
    inValid[2] = 1'b1; inMsg[2] = {2'd2, 2'd0, 8'hD2};
    #2;
    check(inReady[0] && inReady[1] && inReady[2], "R6",
          int'({inReady[2], inReady[1], inReady[0]}), 7);
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 3; i++) inValid[i] = 1'b0;
    #1;
    check(outValid[1] && outMsg[1] == {2'd0, 2'd1, 8'hD0}, "R6", int'(outMsg[1]), 12'h1D0);
    check(outValid[2] && outMsg[2] == {2'd1, 2'd2, 8'hD1}, "R6", int'(outMsg[2]), 12'h6D1);
    check(outValid[0] && outMsg[0] == {2'd2, 2'd0, 8'hD2}, "R6", int'(outMsg[0]), 12'h8D2);
    @(posedge clk);

    // R7/R8/R9 contention for the local output while it is stalled
    @(negedge clk);
    outReady[0] = 1'b0;
    inValid[0] = 1'b1; inMsg[0] = {2'd0, 2'd0, 8'hC0};
    inValid[1] = 1'b1; inMsg[1] = {2'd1, 2'd0, 8'hC1};
    inValid[2] = 1'b1; inMsg[2] = {2'd2, 2'd0, 8'hC2};
    #2;
    check(inReady[0] && !inReady[1] && !inReady[2], "R7",
          int'({inReady[2], inReady[1], inReady[0]}), 1);
    @(posedge clk);
    @(negedge clk);
    inValid[0] = 1'b0;
    #2;
    check(inReady[1] && !inReady[2], "R7",
          int'({inReady[2], inReady[1], inReady[0]}), 2);
    @(posedge clk);
    @(negedge clk);
    inValid[1] = 1'b0;
    #2;
    check(!inReady[2], "R8", int'(inReady[2]), 0);
    check(outValid[0] && outMsg[0] == {2'd0, 2'd0, 8'hC0}, "R9", int'(outMsg[0]), 12'h0C0);
    @(posedge clk);
    @(negedge clk);
    #2;
    check(outValid[0] && outMsg[0] == {2'd0, 2'd0, 8'hC0}, "R9", int'(outMsg[0]), 12'h0C0);
    check(!inReady[2], "R8", int'(inReady[2]), 0);
    outReady[0] = 1'b1;

    nGot = 0;
    for (int c = 0; c < 10; c++) begin
      bool_step: begin
        logic takeY;
        takeY = inValid[2] && inReady[2];
        if (outValid[0] && nGot < 3) begin
          got[nGot] = outMsg[0];
          nGot++;
        end
        @(posedge clk);
        @(negedge clk);
        if (takeY) inValid[2] = 1'b0;
        #2;
      end
    end
    check(nGot == 3, "R8", nGot, 3);
    check(got[0] == {2'd0, 2'd0, 8'hC0}, "R8", int'(got[0]), 12'h0C0);
    check(got[1] == {2'd1, 2'd0, 8'hC1}, "R8", int'(got[1]), 12'h4C1);
    check(got[2] == {2'd2, 2'd0, 8'hC2}, "R8", int'(got[2]), 12'h8C2);
    check(!outValid[0], "R8", int'(outValid[0]), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end
endmodule